// File: doc/BRIEF.md
# Timeslot Serial Bus Deserializer

This block sits on the receive side of a trunk interface. A serial line carries frames of 32 interleaved timeslots. Each timeslot is a 10-bit word: eight voice/data bits, then one signaling bit, then one data-valid bit. A one-clock frame sync pulse marks the first bit of timeslot 0. The block counts bits and slots and gathers each word, most significant bit first. When the tenth bit of a word arrives, the block presents the parts of that word on a parallel output together with a one-clock strobe: the payload byte, the signaling bit, the data-valid bit, the timeslot number, a trunk channel number and a reserved-slot flag.

At a 2.56 Mb/s line rate, each payload byte is a 64 kb/s channel. The signaling bit and the data-valid bit are 8 kb/s each. Timeslots 0 and 16 carry no voice. They are flagged and given channel 0, and the other thirty slots are numbered 1 to 30. After the first sync, the counters keep running without further syncs. A sync that does not land on a frame boundary raises a framing error and realigns the counters.

Top module: `tslot_deser`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is 0 and the strobe is low.
- R2: Until the first frame sync has been seen, no strobe is produced, whatever the serial data carries.
- R3: Within a timeslot, the first bit received lands in payload bit 7 and the eighth lands in payload bit 0. The ninth bit is the signaling output and the tenth bit is the data-valid output.
- R4: The strobe is high for exactly one clock per timeslot: the cycle after the clock edge that samples the tenth bit. In that cycle the timeslot number equals the slot the word was sent in.
- R5: Timeslots 1 to 15 map to channels 1 to 15, and timeslots 17 to 31 map to channels 16 to 30.
- R6: Timeslots 0 and 16 are strobed with the reserved flag at 1 and the channel at 0. All other slots have the reserved flag at 0.
- R7: A sync that arrives exactly 320 bits after the previous one raises no error. Without further syncs, the slot count keeps wrapping from 31 to 0.
- R8: A sync that arrives at any other bit position raises the framing error for exactly one cycle, the cycle after that edge. The bit it arrives with is bit 0 of timeslot 0, and a partly received word is dropped.
- R9: Once locked and with no error, strobes are exactly ten clocks apart and the timeslot number advances by one (mod 32) from each strobe to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync, high with the first bit of timeslot 0 |
| sdata_i | input | 1 | Serial data |
| slot_stb_o | output | 1 | One-cycle strobe: a word is presented |
| slot_num_o | output | 5 | Timeslot number of the presented word |
| chan_num_o | output | 5 | Trunk channel number (0 for reserved slots) |
| payload_o | output | 8 | Voice/data byte |
| sig_o | output | 1 | Signaling bit |
| dvalid_o | output | 1 | Data-valid bit |
| reserved_o | output | 1 | Slot carries no voice payload |
| frame_err_o | output | 1 | One-cycle framing error pulse |

## Verification
The bench tries four kinds of input. Serial data with no sync present shows whether the block stays silent before it locks. Frames that start with a sync on every boundary check that the fields land in the right places and that slots map to the right channels. A frame that runs without a sync tells free-running counters apart from counters that depend on the sync. A sync injected in the middle of a slot checks the error pulse and the realignment, because the next word must come out as slot 0. The payload of each word depends on both the slot and the frame, so bit-order mistakes and mistakes in the slot or channel numbering give wrong values on the outputs.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    localparam int unsigned SLOTS   = 32;
    localparam int unsigned PAY_W   = 8;
    localparam int unsigned WORD_W  = PAY_W + 2;
    localparam int unsigned SLOT_W  = $clog2(SLOTS);
    localparam int unsigned BIT_W   = $clog2(WORD_W);

    typedef struct packed {
        logic              stb;
        logic [SLOT_W-1:0] slot;
        logic [SLOT_W-1:0] chan;
        logic [PAY_W-1:0]  pay;
        logic              sig;
        logic              dv;
        logic              rsv;
        logic              err;
    } tsd_out_t;

endpackage

// File: rtl/tsd_bit_timer.sv
module tsd_bit_timer
    import tsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    output logic              active_o,
    output logic              last_bit_o,
    output logic [SLOT_W-1:0] cur_slot_o,
    output logic              misalign_o
);

    typedef struct packed {
        logic              locked;
        logic [BIT_W-1:0]  bitc;
        logic [SLOT_W-1:0] slot;
    } tmr_t;

    tmr_t st_d, st_q;

    logic [BIT_W-1:0]  cur_bit;
    logic [SLOT_W-1:0] cur_slot;

    always_comb begin
        st_d     = st_q;
        cur_bit  = fsync_i ? '0 : st_q.bitc;
        cur_slot = fsync_i ? '0 : st_q.slot;

        misalign_o = fsync_i && st_q.locked &&
                     ((st_q.bitc != '0) || (st_q.slot != '0));
        active_o   = st_q.locked || fsync_i;
        last_bit_o = active_o && (cur_bit == BIT_W'(WORD_W - 1));
        cur_slot_o = cur_slot;

        if (active_o) begin
            st_d.locked = 1'b1;
            if (cur_bit == BIT_W'(WORD_W - 1)) begin
                st_d.bitc = '0;
                if (cur_slot == SLOT_W'(SLOTS - 1)) begin
                    st_d.slot = '0;
                end else begin
                    st_d.slot = cur_slot + 1'b1;
                end
            end else begin
                st_d.bitc = cur_bit + 1'b1;
                st_d.slot = cur_slot;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tsd_shifter.sv
module tsd_shifter
    import tsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              sdata_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-2:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (shift_i) begin
            sh_d = {sh_q[WORD_W-3:0], sdata_i};
        end
        word_o = {sh_q, sdata_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/tsd_slot_map.sv
module tsd_slot_map
    import tsd_pkg::*;
#(
    parameter int unsigned RSV_LO = 0,
    parameter int unsigned RSV_HI = 16
) (
    input  logic [SLOT_W-1:0] slot_i,
    output logic [SLOT_W-1:0] chan_o,
    output logic              rsv_o
);

    logic [SLOT_W-1:0] skip;

    always_comb begin
        rsv_o = (slot_i == SLOT_W'(RSV_LO)) || (slot_i == SLOT_W'(RSV_HI));
        skip  = '0;
        if (slot_i > SLOT_W'(RSV_LO)) skip = skip + 1'b1;
        if (slot_i > SLOT_W'(RSV_HI)) skip = skip + 1'b1;
        chan_o = rsv_o ? '0 : (slot_i - skip + 1'b1);
    end

endmodule

// File: rtl/tslot_deser.sv
module tslot_deser
    import tsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync_i,
    input  logic              sdata_i,
    output logic              slot_stb_o,
    output logic [4:0]        slot_num_o,
    output logic [4:0]        chan_num_o,
    output logic [7:0]        payload_o,
    output logic              sig_o,
    output logic              dvalid_o,
    output logic              reserved_o,
    output logic              frame_err_o
);

    logic              active;
    logic              last_bit;
    logic              misalign;
    logic [SLOT_W-1:0] cur_slot;
    logic [WORD_W-1:0] word;
    logic [SLOT_W-1:0] chan;
    logic              rsv;

    tsd_out_t out_d, out_q;

    tsd_bit_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync_i    (fsync_i),
        .active_o   (active),
        .last_bit_o (last_bit),
        .cur_slot_o (cur_slot),
        .misalign_o (misalign)
    );

    tsd_shifter u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (active),
        .sdata_i (sdata_i),
        .word_o  (word)
    );

    tsd_slot_map #(
        .RSV_LO (0),
        .RSV_HI (SLOTS / 2)
    ) u_map (
        .slot_i (cur_slot),
        .chan_o (chan),
        .rsv_o  (rsv)
    );

    always_comb begin
        out_d     = out_q;
        out_d.stb = 1'b0;
        out_d.err = misalign;
        if (last_bit) begin
            out_d.stb  = 1'b1;
            out_d.slot = cur_slot;
            out_d.chan = chan;
            out_d.rsv  = rsv;
            out_d.pay  = word[WORD_W-1 -: PAY_W];
            out_d.sig  = word[1];
            out_d.dv   = word[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign slot_stb_o  = out_q.stb;
    assign slot_num_o  = out_q.slot;
    assign chan_num_o  = out_q.chan;
    assign payload_o   = out_q.pay;
    assign sig_o       = out_q.sig;
    assign dvalid_o    = out_q.dv;
    assign reserved_o  = out_q.rsv;
    assign frame_err_o = out_q.err;

endmodule

// File: rtl/tsd_chk.sv
module tsd_chk
    import tsd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              slot_stb_o,
    input logic [SLOT_W-1:0] slot_num_o,
    input logic [SLOT_W-1:0] chan_num_o,
    input logic              reserved_o,
    input logic              frame_err_o
);

    localparam int unsigned GAP_W = $clog2(2 * WORD_W + 1);

    logic [GAP_W-1:0]  gap_q;
    logic              seen_q;
    logic [SLOT_W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            prev_q <= '0;
        end else begin
            if (slot_stb_o) begin
                gap_q  <= '0;
                prev_q <= slot_num_o;
            end else if (gap_q != {GAP_W{1'b1}}) begin
                gap_q <= gap_q + 1'b1;
            end
            if (frame_err_o) begin
                seen_q <= 1'b0;
            end else if (slot_stb_o) begin
                seen_q <= 1'b1;
            end
        end
    end

    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb_o |=> !slot_stb_o);

    a_r8_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o);

    a_r6_reserved_chan0: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb_o && reserved_o) |-> (chan_num_o == '0));

    a_r5_chan_range: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb_o && !reserved_o) |->
            (chan_num_o != '0) && (chan_num_o <= slot_num_o));

    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb_o && seen_q && !frame_err_o) |->
            (gap_q == GAP_W'(WORD_W - 1)));

    a_r9_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb_o && seen_q && !frame_err_o) |->
            (slot_num_o == SLOT_W'(prev_q + 1'b1)));

endmodule

bind tslot_deser tsd_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_stb_o  (slot_stb_o),
    .slot_num_o  (slot_num_o),
    .chan_num_o  (chan_num_o),
    .reserved_o  (reserved_o),
    .frame_err_o (frame_err_o)
);

// File: tb/sim_tslot_deser.sv
module sim_tslot_deser;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       sdata = 1'b0;
    logic       stb;
    logic [4:0] slot_num;
    logic [4:0] chan_num;
    logic [7:0] payload;
    logic       sig;
    logic       dvalid;
    logic       rsv;
    logic       ferr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    // word layout in the table: {payload[7:0], signaling, data-valid}
    localparam logic [9:0] VEC [8] = '{
        10'b1010_0101_1_1, 10'b0000_0000_0_0, 10'b1111_1111_1_1,
        10'b1000_0001_0_1, 10'b0111_1110_1_0, 10'b0011_1100_0_1,
        10'b1100_0011_1_1, 10'b0101_1010_0_0
    };

    tslot_deser u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsync_i     (fsync),
        .sdata_i     (sdata),
        .slot_stb_o  (stb),
        .slot_num_o  (slot_num),
        .chan_num_o  (chan_num),
        .payload_o   (payload),
        .sig_o       (sig),
        .dvalid_o    (dvalid),
        .reserved_o  (rsv),
        .frame_err_o (ferr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] word_of(input int slot, input int fr);
        logic [9:0] v;
        v = VEC[(slot + fr) % 8];
        return {v[9:2] + 8'(slot * 3), v[1] ^ 1'(slot), v[0]};
    endfunction

    function automatic logic [4:0] chan_of(input int slot);
        if (slot == 0 || slot == 16) return 5'd0;
        if (slot < 16) return 5'(slot);
        return 5'(slot - 1);
    endfunction

    task automatic send_bit(input logic b, input logic fs);
        @(negedge clk);
        sdata = b;
        fsync = fs;
        @(posedge clk);
        #1;
        fsync = 1'b0;
    endtask

    task automatic send_word(input int slot, input int fr, input logic fs,
                             input logic exp_err, input logic exp_out);
        logic [9:0] w;
        w = word_of(slot, fr);
        for (int i = 0; i < 10; i++) begin
            send_bit(w[9-i], fs && (i == 0));
            if (i == 0) chk(ferr == exp_err, "R7/R8 err at sync", 32'(ferr), 32'(exp_err));
            if (i == 1) chk(ferr == 1'b0, "R8 err one cycle", 32'(ferr), 0);
            if (i < 9) begin
                chk(stb == 1'b0, "R9 no strobe mid-word", 32'(stb), 0);
            end else if (!exp_out) begin
                chk(stb == 1'b0, "R2 no strobe before sync", 32'(stb), 0);
            end else begin
                chk(stb == 1'b1, "R4 strobe after tenth bit", 32'(stb), 1);
                chk(slot_num == 5'(slot), "R4 slot number", 32'(slot_num), 32'(slot));
                chk(payload == w[9:2], "R3 payload MSB first", 32'(payload), 32'(w[9:2]));
                chk(sig == w[1], "R3 signaling bit", 32'(sig), 32'(w[1]));
                chk(dvalid == w[0], "R3 data-valid bit", 32'(dvalid), 32'(w[0]));
                chk(chan_num == chan_of(slot), "R5 channel map", 32'(chan_num),
                    32'(chan_of(slot)));
                chk(rsv == (slot == 0 || slot == 16), "R6 reserved flag", 32'(rsv),
                    32'(slot == 0 || slot == 16));
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk({stb, slot_num, chan_num, payload, sig, dvalid, rsv, ferr} == '0,
            "R1 outputs during reset", 32'(payload), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(stb == 1'b0 && ferr == 1'b0, "R1 after reset", 32'(stb), 0);

        // R2: data without sync
        send_word(5, 0, 1'b0, 1'b0, 1'b0);
        send_word(9, 1, 1'b0, 1'b0, 1'b0);

        // frames 0,1 with sync on boundary, frame 2 free-running (R7)
        for (int f = 0; f < 3; f++) begin
            for (int s = 0; s < 32; s++) begin
                send_word(s, f, (f < 2) && (s == 0), 1'b0, 1'b1);
            end
        end

        // frame 3: early sync in slot 3 bit 4 (R8)
        for (int s = 0; s < 3; s++) send_word(s, 3, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 4; i++) begin
            send_bit(1'(i), 1'b0);
            chk(stb == 1'b0, "R8 partial word", 32'(stb), 0);
        end
        for (int s = 0; s < 32; s++) send_word(s, 4, s == 0, s == 0, 1'b1);

        // frame 5: sync back on a 320-bit boundary (R7)
        for (int s = 0; s < 32; s++) send_word(s, 5, s == 0, 1'b0, 1'b1);

        finish_run();
    end

endmodule